// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns memory requests from a processor core into external cycles on a bus whose low address byte and data share one set of eight lines. The upper address bits have their own dedicated lines. Each bus cycle lasts a fixed five clocks. In the first clock the low address byte appears on the shared lines while the address strobe is high, so external logic can latch it. After a one-clock gap the lines carry data for a two-clock data strobe. On a write the block drives the data. On a read it releases the lines and captures what the addressed device returns.

The block has a read/write line and an opcode-fetch indicator. The fetch indicator covers the whole fetch cycle, including its data strobe. A done pulse marks the end of every cycle. A requester may hold a new request while a cycle is in progress, and it is taken on the done clock, so cycles can follow each other with no idle clock between them. While the core is in a power-saving mode, the block starts no new cycle, and so no strobes appear. The shared lines are brought out as a split output, output-enable and input triple for the pad ring.

Top module: `mux_bus_seq`

## Requirements
- R1: In the first clock after synchronous active-low reset is released, these outputs hold: `as_o`=0, `ds_o`=0, `rw_o`=1, `ad_oe_o`=0, `li_o`=0, `done_o`=0, `addr_hi_o`=0. `req_ready_o`=1 when `lp_mode_i`=0.
- R2: A request taken at a clock edge produces a five-clock bus cycle (phases 0 to 4) starting in the next clock. A request taken on the done clock starts its address strobe exactly five clocks after the previous one.
- R3: The address strobe is high only in phase 0. In that phase `ad_oe_o`=1 and `ad_o` carries address bits [7:0].
- R4: `addr_hi_o` carries address bits [12:8] of the current request in every phase of its cycle.
- R5: The data strobe is high in phases 2 and 3 only. It is never high together with the address strobe.
- R6: On a write (`req_write_i`=1), `rw_o`=0 in all five phases, and `ad_oe_o`=1 with `ad_o` equal to the write data in phases 1 to 4.
- R7: On a read, `rw_o`=1 and `ad_oe_o`=0 in phases 1 to 4. In phase 4, `rd_data_o` equals the value on `ad_i` during phase 3, the last data-strobe clock. Values on `ad_i` in other phases have no effect.
- R8: `li_o` is 1 in all five phases of a cycle whose request had `req_fetch_i`=1, and 0 in every phase of other cycles.
- R9: When no cycle is running, `as_o`=0, `ds_o`=0, `ad_oe_o`=0, `li_o`=0 and `rw_o`=1.
- R10: `req_ready_o` is 1 only when `lp_mode_i`=0 and the block is either idle or in phase 4. A request presented while `req_ready_o`=0 is not taken and is not remembered.
- R11: While `lp_mode_i`=1, no new cycle starts and both strobes stay low once the running cycle ends. A cycle already running when the mode is entered runs to its done pulse.
- R12: `done_o` is high for exactly one clock per cycle, in phase 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (one clock per phase) |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 13 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | 1 = opcode fetch |
| lp_mode_i | input | 1 | Power-saving mode active |
| req_ready_o | output | 1 | Request is taken at this edge if valid |
| addr_hi_o | output | 5 | Dedicated upper address lines |
| ad_o | output | 8 | Shared lines, output value |
| ad_oe_o | output | 1 | Shared lines, output enable |
| ad_i | input | 8 | Shared lines, input value |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rw_o | output | 1 | 1 = read, 0 = write |
| li_o | output | 1 | Opcode-fetch indicator |
| rd_data_o | output | 8 | Captured read data |
| done_o | output | 1 | Cycle completion pulse |

## Verification
Two events can fall in the same clock: the done phase of one cycle and the taking of the next request. Together they decide whether the sequencer keeps a strict five-clock rhythm. The bench holds `req_valid_i` high with new fields through a running cycle. It then judges that `done_o` and `req_ready_o` are both high in phase 4, and that the next address strobe, carrying the new low address byte, comes exactly one clock later. Entry into the power-saving mode in the middle of a cycle is the second overlap. The bench checks that the running cycle still reaches its done pulse and that the held request is then refused.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
// Package mbs_pkg
// Types shared by the multiplexed bus sequencer. The phase kind names the part
// of a bus cycle the sequencer is in; the output decoder keys off it alone.
package mbs_pkg;

    typedef enum logic [2:0] {
        PK_IDLE = 3'd0,   // no cycle running
        PK_ADDR = 3'd1,   // address strobe window
        PK_GAP  = 3'd2,   // turnaround between address and data
        PK_DATA = 3'd3,   // data strobe window
        PK_TAIL = 3'd4    // closing clock, done pulse
    } phase_kind_e;

endpackage

// File: rtl/mbs_phase_ctr.sv
`timescale 1ns/1ps
// Module mbs_phase_ctr
// Counts the clocks of one bus cycle and decides when a new request is taken.
// Assumes the cycle is laid out as AS_CLKS address clocks, GAP_CLKS turnaround
// clocks, DS_CLKS data-strobe clocks and one closing clock. A request is taken
// when idle or in the closing clock, never in a power-saving mode.
module mbs_phase_ctr
    import mbs_pkg::*;
#(
    parameter int AS_CLKS  = 1,
    parameter int GAP_CLKS = 1,
    parameter int DS_CLKS  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        lp_mode,
    output logic        ready,
    output logic        accept,
    output logic        capture,
    output phase_kind_e kind
);

    localparam int CYC_LEN  = AS_CLKS + GAP_CLKS + DS_CLKS + 1;
    localparam int CW       = $clog2(CYC_LEN);
    localparam logic [CW-1:0] LAST_IDX = CW'(CYC_LEN - 1);
    localparam logic [CW-1:0] CAP_IDX  = CW'(CYC_LEN - 2);
    localparam logic [CW-1:0] GAP_IDX  = CW'(AS_CLKS);
    localparam logic [CW-1:0] DS_IDX   = CW'(AS_CLKS + GAP_CLKS);
    localparam logic [CW-1:0] TAIL_IDX = CW'(AS_CLKS + GAP_CLKS + DS_CLKS);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          last_clk;

    // Purpose: detect the closing clock of a running cycle.
    always_comb begin
        last_clk = active_q && (cnt_q == LAST_IDX);
    end

    // Purpose: handshake decode, open when idle or closing and not in low power.
    always_comb begin
        ready   = !lp_mode && (!active_q || last_clk);
        accept  = req_valid && ready;
        capture = active_q && (cnt_q == CAP_IDX);
    end

    // Purpose: advance the phase counter and start or end cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (last_clk) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + CW'(1);
        end
    end

    // Purpose: map the counter onto the phase kind seen by the pin decoder.
    always_comb begin
        if (!active_q) begin
            kind = PK_IDLE;
        end else if (cnt_q < GAP_IDX) begin
            kind = PK_ADDR;
        end else if (cnt_q < DS_IDX) begin
            kind = PK_GAP;
        end else if (cnt_q < TAIL_IDX) begin
            kind = PK_DATA;
        end else begin
            kind = PK_TAIL;
        end
    end

endmodule

// File: rtl/mbs_req_hold.sv
`timescale 1ns/1ps
// Module mbs_req_hold
// Holds the fields of the request being served so the requester may change its
// inputs as soon as the request is taken, and captures read data from the
// shared lines on the last data-strobe clock. Assumes accept and capture never
// coincide (capture is one clock before the closing clock).
module mbs_req_hold #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata,
    output logic              held_write,
    output logic              held_fetch,
    output logic [DATA_W-1:0] rd_data
);

    // Purpose: latch the request fields at the edge where it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr  <= '0;
            held_wdata <= '0;
            held_write <= 1'b0;
            held_fetch <= 1'b0;
        end else if (accept) begin
            held_addr  <= req_addr;
            held_wdata <= req_wdata;
            held_write <= req_write;
            held_fetch <= req_fetch;
        end
    end

    // Purpose: sample the shared lines at the end of the data strobe on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture && !held_write) begin
            rd_data <= bus_in;
        end
    end

endmodule

// File: rtl/mbs_pin_drive.sv
`timescale 1ns/1ps
// Module mbs_pin_drive
// Decodes the phase kind and the held request into the bus pins. Purely
// combinational from registered state, so no input reaches a pin in the same
// clock. Assumes DATA_W low address bits share the data lines.
module mbs_pin_drive
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  phase_kind_e       kind,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic [DATA_W-1:0] held_wdata,
    input  logic              held_write,
    input  logic              held_fetch,
    output logic [ADDR_W-1:DATA_W] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              as_str,
    output logic              ds_str,
    output logic              rw,
    output logic              li,
    output logic              done
);

    logic busy;

    // Purpose: strobe, direction and fetch decode per phase kind.
    always_comb begin
        busy   = (kind != PK_IDLE);
        as_str = (kind == PK_ADDR);
        ds_str = (kind == PK_DATA);
        done   = (kind == PK_TAIL);
        rw     = busy ? !held_write : 1'b1;
        li     = busy && held_fetch;
        addr_hi = held_addr[ADDR_W-1:DATA_W];
    end

    // Purpose: shared-line multiplexer, address first, then write data.
    always_comb begin
        case (kind)
            PK_ADDR: begin
                ad_oe  = 1'b1;
                ad_out = held_addr[DATA_W-1:0];
            end
            PK_GAP, PK_DATA, PK_TAIL: begin
                ad_oe  = held_write;
                ad_out = held_write ? held_wdata : '0;
            end
            default: begin
                ad_oe  = 1'b0;
                ad_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/mux_bus_seq.sv
`timescale 1ns/1ps
// Module mux_bus_seq (top)
// Sequences processor requests onto a bus where the low address byte and data
// share one set of lines. Fixed cycle: address strobe, turnaround, data strobe,
// closing clock with done. Assumes the requester holds a request until
// req_ready_o is seen high with it, and that the pad ring merges ad_o/ad_oe_o/ad_i.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int AS_CLKS  = 1,
    parameter int GAP_CLKS = 1,
    parameter int DS_CLKS  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    input  logic                   req_write_i,
    input  logic                   req_fetch_i,
    input  logic                   lp_mode_i,
    output logic                   req_ready_o,
    output logic [ADDR_W-1:DATA_W] addr_hi_o,
    output logic [DATA_W-1:0]      ad_o,
    output logic                   ad_oe_o,
    input  logic [DATA_W-1:0]      ad_i,
    output logic                   as_o,
    output logic                   ds_o,
    output logic                   rw_o,
    output logic                   li_o,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   done_o
);

    phase_kind_e       kind;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic              held_write;
    logic              held_fetch;

    mbs_phase_ctr #(
        .AS_CLKS  (AS_CLKS),
        .GAP_CLKS (GAP_CLKS),
        .DS_CLKS  (DS_CLKS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid_i),
        .lp_mode   (lp_mode_i),
        .ready     (req_ready_o),
        .accept    (accept),
        .capture   (capture),
        .kind      (kind)
    );

    mbs_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr_i),
        .req_wdata  (req_wdata_i),
        .req_write  (req_write_i),
        .req_fetch  (req_fetch_i),
        .bus_in     (ad_i),
        .held_addr  (held_addr),
        .held_wdata (held_wdata),
        .held_write (held_write),
        .held_fetch (held_fetch),
        .rd_data    (rd_data_o)
    );

    mbs_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .kind       (kind),
        .held_addr  (held_addr),
        .held_wdata (held_wdata),
        .held_write (held_write),
        .held_fetch (held_fetch),
        .addr_hi    (addr_hi_o),
        .ad_out     (ad_o),
        .ad_oe      (ad_oe_o),
        .as_str     (as_o),
        .ds_str     (ds_o),
        .rw         (rw_o),
        .li         (li_o),
        .done       (done_o)
    );

endmodule

// File: rtl/mbs_checker.sv
`timescale 1ns/1ps
// Module mbs_checker
// Protocol properties of the multiplexed bus sequencer, observed at its pins.
// Bound into every instance of mux_bus_seq.
module mbs_checker #(
    parameter int HI_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lp_mode_i,
    input logic            req_ready_o,
    input logic [HI_W-1:0] addr_hi_o,
    input logic            ad_oe_o,
    input logic            as_o,
    input logic            ds_o,
    input logic            rw_o,
    input logic            li_o,
    input logic            done_o
);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_o && ds_o));

    a_r3_as_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> ad_oe_o);

    a_r6_write_drives_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && !rw_o) |-> ad_oe_o);

    a_r7_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && rw_o) |-> !ad_oe_o);

    a_r4_fields_stable_in_ds: assert property (@(posedge clk) disable iff (!rst_n)
        ds_o |-> ($stable(rw_o) && $stable(addr_hi_o) && $stable(li_o)));

    a_r12_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ds_o && $past(ds_o)));

    a_r12_strobe_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_o) |-> done_o);

    a_r10_lp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode_i |-> !req_ready_o);

    a_r11_as_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_o) |-> $past(req_ready_o && !lp_mode_i));

endmodule

bind mux_bus_seq mbs_checker #(.HI_W(ADDR_W - DATA_W)) u_mbs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_mode_i   (lp_mode_i),
    .req_ready_o (req_ready_o),
    .addr_hi_o   (addr_hi_o),
    .ad_oe_o     (ad_oe_o),
    .as_o        (as_o),
    .ds_o        (ds_o),
    .rw_o        (rw_o),
    .li_o        (li_o),
    .done_o      (done_o)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;

    typedef struct packed {
        logic [12:0] a;
        logic [7:0]  wd;
        logic        wr;
        logic        fe;
        logic [7:0]  rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{a: 13'h1A5C, wd: 8'h00, wr: 1'b0, fe: 1'b1, rd: 8'hC3},
        '{a: 13'h0001, wd: 8'h7E, wr: 1'b1, fe: 1'b0, rd: 8'h00},
        '{a: 13'h1FFF, wd: 8'h00, wr: 1'b0, fe: 1'b0, rd: 8'hFF},
        '{a: 13'h0100, wd: 8'hA5, wr: 1'b1, fe: 1'b0, rd: 8'h00},
        '{a: 13'h0FF0, wd: 8'h00, wr: 1'b0, fe: 1'b1, rd: 8'h00},
        '{a: 13'h1234, wd: 8'h00, wr: 1'b0, fe: 1'b0, rd: 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        lp_mode = 1'b0;
    logic [7:0]  ad_in = '0;
    logic        req_ready;
    logic [12:8] addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic        as_s, ds_s, rw_s, li_s, done_s;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mux_bus_seq u_mux_bus_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .req_write_i (req_write),
        .req_fetch_i (req_fetch),
        .lp_mode_i   (lp_mode),
        .req_ready_o (req_ready),
        .addr_hi_o   (addr_hi),
        .ad_o        (ad_out),
        .ad_oe_o     (ad_oe),
        .ad_i        (ad_in),
        .as_o        (as_s),
        .ds_o        (ds_s),
        .rw_o        (rw_s),
        .li_o        (li_s),
        .rd_data_o   (rd_data),
        .done_o      (done_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input vec_t v);
        req_addr  = v.a;
        req_wdata = v.wd;
        req_write = v.wr;
        req_fetch = v.fe;
    endtask

    // Checks one phase of a cycle against expectations derived from the requirements.
    task automatic chk_phase(input vec_t v, input int p);
        chk("R3 as_o",       32'(as_s), 32'(p == 0));
        chk("R5 ds_o",       32'(ds_s), 32'(p == 2 || p == 3));
        chk("R4 addr_hi_o",  32'(addr_hi), 32'(v.a[12:8]));
        chk("R6 R7 rw_o",    32'(rw_s), 32'(!v.wr));
        chk("R6 R7 ad_oe_o", 32'(ad_oe), 32'(p == 0 || v.wr));
        if (p == 0) chk("R3 ad_o addr", 32'(ad_out), 32'(v.a[7:0]));
        else if (v.wr) chk("R6 ad_o wdata", 32'(ad_out), 32'(v.wd));
        chk("R8 li_o",       32'(li_s), 32'(v.fe));
        chk("R12 done_o",    32'(done_s), 32'(p == 4));
        chk("R10 req_ready_o", 32'(req_ready), 32'(p == 4));
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, 32'({as_s, ds_s, ad_oe, li_s, rw_s}), 32'(5'b00001));
    endtask

    // Runs one isolated cycle: request at a falling edge, taken at the next rising edge.
    task automatic run_cycle(input vec_t v);
        set_req(v);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk_phase(v, 0);
        for (int p = 1; p < 5; p++) begin
            @(negedge clk);
            chk_phase(v, p);
            if (p == 4 && !v.wr) chk("R7 rd_data_o", 32'(rd_data), 32'(v.rd));
            if (p == 4) ad_in = 8'h3C;
            else if (p == 3) ad_in = v.rd;
            else ad_in = ~v.rd;
        end
        @(negedge clk);
        chk_idle("R9 idle after cycle");
        chk("R9 done_o idle", 32'(done_s), 32'(0));
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog expired actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 strobes/oe/li/done", 32'({as_s, ds_s, ad_oe, li_s, done_s}), 32'(0));
        chk("R1 rw_o", 32'(rw_s), 32'(1));
        chk("R1 addr_hi_o", 32'(addr_hi), 32'(0));
        chk("R1 req_ready_o", 32'(req_ready), 32'(1));

        // Table walk: one cycle per vector, each read captures phase-3 data only.
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i]);
        end

        // R2 back-to-back: second request held through the first cycle, taken on done.
        set_req(VECS[0]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 first as_o", 32'(as_s), 32'(1));
        req_addr = 13'h0A0B; req_wdata = 8'h3C; req_write = 1'b1; req_fetch = 1'b0;
        for (int p = 1; p < 4; p++) begin
            @(negedge clk);
            chk("R10 busy no restart as_o", 32'(as_s), 32'(0));
            chk("R10 busy not ready", 32'(req_ready), 32'(0));
        end
        @(negedge clk);
        chk("R12 done with held request", 32'(done_s), 32'(1));
        chk("R10 ready on done clock", 32'(req_ready), 32'(1));
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 second as_o five clocks later", 32'(as_s), 32'(1));
        chk("R2 second low addr", 32'(ad_out), 32'(8'h0B));
        chk("R2 second addr_hi", 32'(addr_hi), 32'(5'h0A));
        chk("R12 done single clock", 32'(done_s), 32'(0));
        chk("R6 second rw_o", 32'(rw_s), 32'(0));
        repeat (4) @(negedge clk);
        chk("R12 second done", 32'(done_s), 32'(1));
        @(negedge clk);
        chk_idle("R9 idle after back-to-back");

        // R11: power-saving mode blocks new cycles, held request is dropped.
        lp_mode = 1'b1;
        set_req(VECS[2]);
        req_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R11 no strobes in lp", 32'({as_s, ds_s}), 32'(0));
            chk("R10 not ready in lp", 32'(req_ready), 32'(0));
        end
        req_valid = 1'b0;
        lp_mode = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 refused request not kept", 32'(as_s), 32'(0));
        end

        // R11: mode entered mid-cycle, running cycle completes.
        set_req(VECS[5]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 cycle started", 32'(as_s), 32'(1));
        @(negedge clk);
        lp_mode = 1'b1;
        @(negedge clk);
        chk("R11 ds_o continues", 32'(ds_s), 32'(1));
        @(negedge clk);
        ad_in = VECS[5].rd;
        @(negedge clk);
        chk("R11 done reached", 32'(done_s), 32'(1));
        chk("R11 read data", 32'(rd_data), 32'(VECS[5].rd));
        chk("R11 not ready on done in lp", 32'(req_ready), 32'(0));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R11 no new as_o", 32'(as_s), 32'(0));
        end
        req_valid = 1'b0;
        lp_mode = 1'b0;
        @(negedge clk);
        chk_idle("R9 idle after lp");

        // R1: reset in mid-cycle returns to idle.
        set_req(VECS[1]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after mid-cycle reset");
        chk("R1 done_o after reset", 32'(done_s), 32'(0));

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule